// File: doc/BRIEF.md
# Runtime-Modulus End-Around-Carry Adder

This block adds two residues modulo a Mersenne number 2^p − 1 in a single combinational pass. The exponent p arrives on its own input at run time, so one 16-bit datapath serves every modulus from 2^2 − 1 up to 2^16 − 1. The modulus is never stored. A per-bit mask, in which bit i is set when i < p, sets the width of the arithmetic. The carry that leaves bit p − 1 is routed back into bit 0.

Two full-width sums are formed side by side: one with carry-in 0 and one with carry-in 1. Both come from one set of carry-select blocks. A late multiplexer picks the carry-in 1 sum in two cases: when the carry-in 0 sum overflows past bit p − 1, or when it lands exactly on the all-ones pattern, which is the second encoding of zero. The chosen sum is masked, so every bit at or above p reads 0. The block is meant for modular multiply and square datapaths that accumulate partial products without a divider.

The block is purely combinational and has no clock or reset. It is a value-in, value-out arithmetic unit with no stream interface, so it has no back-pressure rules. The operands are expected to be already reduced below the modulus, and p is expected to lie between 2 and 16.

Top module: `eac_adder`

## Requirements
- R1: For every p from 2 to 16 and operands below 2^p − 1, sum_o equals (op_a + op_b) mod (2^p − 1).
- R2: Every bit of sum_o at position p or above is 0.
- R3: When op_a + op_b equals 2^p − 1 exactly, sum_o is 0. The all-ones pattern in the low p bits is never output.
- R4: When op_a + op_b reaches 2^p or more, the carry out of bit p − 1 is added back at bit 0, so sum_o equals op_a + op_b − 2^p + 1. For example, 2^(p−1) + 2^(p−1) gives 1.
- R5: When op_a + op_b is below 2^p − 1, sum_o equals op_a + op_b unchanged. This includes zero operands and a sum of 2^p − 2.
- R6: Operand bits at position p or above are ignored. Setting them does not change sum_o.
- R7: With p = 16, the carry out of bit 15 wraps into bit 0: 0xFFFE + 0x0001 gives 0x0000, 0xFFFE + 0xFFFE gives 0xFFFD, and 0x8000 + 0x8000 gives 0x0001.
- R8: sum_o is always below 2^p − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First residue, below 2^p − 1 in its low p bits |
| op_b | input | 16 | Second residue, below 2^p − 1 in its low p bits |
| exp_p | input | 5 | Modulus exponent p, legal range 2 to 16 |
| sum_o | output | 16 | Reduced sum, zero at and above bit p |

## Verification
The bench aims at the two places where the wrap point moves with p.

Sums that land exactly on 2^p − 1 are tried for every p. A design that skips the fold would return the all-ones pattern instead of 0. Sums that just cross 2^p are also tried for every p. A design that takes the carry from a fixed bit 15 would miss the wrap for small p and leave a result too large by 2^p − 1.

Garbage is placed above bit p in the operands. A design that does not mask its inputs would let the garbage leak into the result or corrupt the carry tap. The p = 16 case tests that the top carry, which leaves the word entirely, is still fed back.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int unsigned EAC_WIDTH = 16;
  localparam int unsigned EAC_BLOCK = 4;
  localparam int unsigned EAC_PW    = $clog2(EAC_WIDTH + 1);

  typedef logic [EAC_WIDTH-1:0] eac_word_t;
endpackage

// File: rtl/eac_mask_gen.sv
module eac_mask_gen #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PW    = 5
) (
  input  logic [PW-1:0]    exp_p,
  output logic [WIDTH-1:0] low_mask,
  output logic [WIDTH-1:0] tap_sel
);
  // low_mask[i] is set for i < p; tap_sel is one-hot at bit p-1
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign low_mask[i] = (exp_p > PW'(i));
    assign tap_sel[i]  = (exp_p == PW'(i + 1));
  end
endmodule

// File: rtl/eac_dual_adder.sv
module eac_dual_adder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned BLK   = 4
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  output logic [WIDTH-1:0] sum_c0,
  output logic [WIDTH-1:0] sum_c1,
  output logic [WIDTH-1:0] cout_c0
);
  localparam int unsigned NBLK = WIDTH / BLK;

  // Each block ripples locally for both block carry-ins; two global
  // select chains (global carry-in 0 and 1) reuse the same block results.
  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    logic [BLK-1:0] gen_v, prop_v;
    logic [BLK:0]   rc_lo, rc_hi;
    logic           cin_g0, cin_g1;

    assign gen_v  = add_a[k*BLK +: BLK] & add_b[k*BLK +: BLK];
    assign prop_v = add_a[k*BLK +: BLK] ^ add_b[k*BLK +: BLK];
    assign rc_lo[0] = 1'b0;
    assign rc_hi[0] = 1'b1;

    for (genvar j = 0; j < BLK; j++) begin : g_rip
      assign rc_lo[j+1] = gen_v[j] | (prop_v[j] & rc_lo[j]);
      assign rc_hi[j+1] = gen_v[j] | (prop_v[j] & rc_hi[j]);
    end

    if (k == 0) begin : g_first
      assign cin_g0 = 1'b0;
      assign cin_g1 = 1'b1;
    end else begin : g_next
      assign cin_g0 = g_blk[k-1].cin_g0 ? g_blk[k-1].rc_hi[BLK] : g_blk[k-1].rc_lo[BLK];
      assign cin_g1 = g_blk[k-1].cin_g1 ? g_blk[k-1].rc_hi[BLK] : g_blk[k-1].rc_lo[BLK];
    end

    for (genvar j = 0; j < BLK; j++) begin : g_out
      assign sum_c0[k*BLK + j]  = prop_v[j] ^ (cin_g0 ? rc_hi[j] : rc_lo[j]);
      assign sum_c1[k*BLK + j]  = prop_v[j] ^ (cin_g1 ? rc_hi[j] : rc_lo[j]);
      assign cout_c0[k*BLK + j] = cin_g0 ? rc_hi[j+1] : rc_lo[j+1];
    end
  end
endmodule

// File: rtl/eac_reduce_ctl.sv
module eac_reduce_ctl #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] sum_c0,
  input  logic [WIDTH-1:0] cout_c0,
  input  logic [WIDTH-1:0] low_mask,
  input  logic [WIDTH-1:0] tap_sel,
  output logic             take_inc
);
  logic wrap_out;
  logic all_ones;

  // carry out of bit p-1, picked through the one-hot tap
  assign wrap_out = |(cout_c0 & tap_sel);
  // low p bits of the carry-in-0 sum are all ones: second zero
  assign all_ones = &(sum_c0 | ~low_mask);
  assign take_inc = wrap_out | all_ones;
endmodule

// File: rtl/eac_adder.sv
module eac_adder #(
  parameter int unsigned WIDTH = eac_pkg::EAC_WIDTH,
  parameter int unsigned BLK   = eac_pkg::EAC_BLOCK,
  parameter int unsigned PW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [PW-1:0]    exp_p,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] low_mask, tap_sel;
  logic [WIDTH-1:0] a_m, b_m;
  logic [WIDTH-1:0] sum_c0, sum_c1, cout_c0;
  logic             take_inc;

  eac_mask_gen #(.WIDTH(WIDTH), .PW(PW)) u_mask (
    .exp_p    (exp_p),
    .low_mask (low_mask),
    .tap_sel  (tap_sel)
  );

  assign a_m = op_a & low_mask;
  assign b_m = op_b & low_mask;

  eac_dual_adder #(.WIDTH(WIDTH), .BLK(BLK)) u_add (
    .add_a   (a_m),
    .add_b   (b_m),
    .sum_c0  (sum_c0),
    .sum_c1  (sum_c1),
    .cout_c0 (cout_c0)
  );

  eac_reduce_ctl #(.WIDTH(WIDTH)) u_ctl (
    .sum_c0   (sum_c0),
    .cout_c0  (cout_c0),
    .low_mask (low_mask),
    .tap_sel  (tap_sel),
    .take_inc (take_inc)
  );

  assign sum_o = (take_inc ? sum_c1 : sum_c0) & low_mask;
endmodule

// File: rtl/eac_adder_chk.sv
module eac_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PW    = 5
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [PW-1:0]    exp_p,
  input logic [WIDTH-1:0] sum_o
);
  always_comb begin
    logic [31:0] modv, av, bv, ov;
    logic        legal;
    modv  = (32'd1 << exp_p) - 32'd1;
    av    = 32'(op_a) & modv;
    bv    = 32'(op_b) & modv;
    ov    = 32'(sum_o);
    legal = (32'(exp_p) >= 32'd2) && (32'(exp_p) <= WIDTH) && (av < modv) && (bv < modv);
    if (legal) begin
      a_r1_residue:    assert (ov == (av + bv) % modv);
      a_r2_upper_zero: assert ((ov & ~modv) == 32'd0);
      a_r8_below_mod:  assert (ov < modv);
      if (av + bv == modv) begin
        a_r3_fold_zero: assert (ov == 32'd0);
      end
    end
  end
endmodule

bind eac_adder eac_adder_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .op_a  (op_a),
  .op_b  (op_b),
  .exp_p (exp_p),
  .sum_o (sum_o)
);

// File: tb/eac_adder_bench.sv
`timescale 1ns/1ps
module eac_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [4:0]  exp_p = 5'd16;
  logic [15:0] sum_o;
  int unsigned n_checks = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  eac_adder u_eac_adder (.op_a(op_a), .op_b(op_b), .exp_p(exp_p), .sum_o(sum_o));

  function automatic int unsigned mod_of(int unsigned p);
    return (32'd1 << p) - 32'd1;
  endfunction

  task automatic chk(input string req, input int unsigned got, input int unsigned exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h (p=%0d a=%0h b=%0h)", req, got, exp, exp_p, op_a, op_b);
    end
  endtask

  task automatic apply(input int unsigned p, input int unsigned a, input int unsigned b);
    @(negedge clk);
    exp_p = 5'(p);
    op_a  = 16'(a);
    op_b  = 16'(b);
    #1;
  endtask

  task automatic t_reset_state();
    apply(16, 0, 0);
    chk("R5 reset zero", 32'(sum_o), 0);
  endtask

  task automatic t_sweep();
    for (int p = 2; p <= 16; p++) begin
      int unsigned m = mod_of(p);
      for (int n = 0; n < 30; n++) begin
        int unsigned a = $urandom % m;
        int unsigned b = $urandom % m;
        apply(p, a, b);
        chk("R1 residue", 32'(sum_o), (a + b) % m);
        chk("R2 upper zero", 32'(sum_o) & ~m, 0);
        chk("R8 below mod", 32'(32'(sum_o) < m), 1);
      end
    end
  endtask

  task automatic t_fold();
    for (int p = 2; p <= 16; p++) begin
      int unsigned m = mod_of(p);
      int unsigned a = 1 + ($urandom % (m - 1));
      apply(p, a, m - a);
      chk("R3 fold to zero", 32'(sum_o), 0);
    end
  endtask

  task automatic t_wrap();
    for (int p = 2; p <= 16; p++) begin
      int unsigned m = mod_of(p);
      int unsigned h = 32'd1 << (p - 1);
      apply(p, m - 1, m - 1);
      chk("R4 wrap max", 32'(sum_o), m - 2);
      apply(p, h, h);
      chk("R4 wrap half", 32'(sum_o), 1);
    end
  endtask

  task automatic t_nowrap();
    for (int p = 2; p <= 16; p++) begin
      int unsigned m = mod_of(p);
      int unsigned x = $urandom % m;
      apply(p, 0, x);
      chk("R5 zero operand", 32'(sum_o), x);
      apply(p, m - 2, 0);
      chk("R5 top sum", 32'(sum_o), m - 2);
    end
  endtask

  task automatic t_upper();
    for (int p = 2; p < 16; p++) begin
      int unsigned m = mod_of(p);
      int unsigned a = $urandom % m;
      int unsigned b = $urandom % m;
      int unsigned ga = ($urandom << p) & 32'hFFFF;
      int unsigned gb = (32'hFFFF << p) & 32'hFFFF;
      apply(p, a | ga, b | gb);
      chk("R6 upper ignored", 32'(sum_o), (a + b) % m);
    end
  endtask

  task automatic t_full();
    apply(16, 16'hFFFE, 16'h0001);
    chk("R7 full fold", 32'(sum_o), 0);
    apply(16, 16'hFFFE, 16'hFFFE);
    chk("R7 full wrap", 32'(sum_o), 32'hFFFD);
    apply(16, 16'h8000, 16'h8000);
    chk("R7 top carry", 32'(sum_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_sweep();
    t_fold();
    t_wrap();
    t_nowrap();
    t_upper();
    t_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule